// File: doc/BRIEF.md
# Coherent Snoop Request Responder

This block serves coherence snoops sent by a system-level coherence controller. Each snoop names a cache line, says whether the line should drop to shared or be invalidated, and carries a presence-check flag. The block claims the cache tag store through a small fixed-priority arbiter that it shares with local fills, writebacks and block stores. It then performs the snoop as one indivisible read-modify-write of the line's tag state and returns exactly one reply per snoop.

When the controller cannot vouch that the line is present, it sets the presence-check flag. The block then spends an extra cycle to decide whether the line is valid and answers with a negative acknowledge when it is not. When the flag is clear, the controller already knows the line is held. The block skips that decision and goes straight from the tag read to the tag write, so the reply arrives one cycle sooner. The line's state update is the same for both flag values.

Only one snoop is in flight at a time. A snoop that is waiting is granted the tag store as soon as the local operation currently holding it finishes, and ahead of any local request that is waiting. This keeps the worst-case reply latency bounded.

Top module: `snoop_responder`

## Requirements
- R1: One snoop is outstanding at most. `req_ready` is low from the cycle after a request is accepted until the cycle after its reply handshake (`rsp_valid` and `rsp_ready` both high).
- R2: Every accepted request produces exactly one reply handshake, so the number of replies equals the number of requests.
- R3: With `req_chk`=1 and a line state of invalid (0), the reply code is NACK (2) and the tag store is not written.
- R4: With `req_chk`=1 and a valid line, the reply is DACK (1) if the line state is modified (3) and ACK (0) otherwise. The updated state is written once.
- R5: With `req_chk`=0, the reply is never NACK. It is DACK (1) when the state returned by the tag read of the atomic update is modified (3), and ACK (0) otherwise. In that case the reply arrives at least one cycle earlier than with `req_chk`=1.
- R6: Tag state encoding is invalid=0, shared=1, exclusive=2, modified=3. An operation of 0 (share) turns a valid line to shared (1). An operation of 1 (invalidate) writes invalid (0). An invalid line stays invalid. The rule is the same for both flag values.
- R7: No local grant (`loc_gnt`) is high from the snoop's tag read until its reply is presented. Tag reads and writes by the snoop only happen with `loc_gnt` all zero.
- R8: A local operation that holds the tag store keeps its grant until it drops its request. A waiting snoop is then granted before any other waiting local request. At most one local grant is high.
- R9: If each local operation holds the tag store for at most a few cycles, a snoop is answered within LAT_MAX cycles of acceptance (default 30).
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_code` is unchanged.
- R11: Out of reset, `req_ready` is high and `rsp_valid`, `tag_rd_en`, `tag_wr_en` and all of `loc_gnt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Snoop request present |
| req_ready | output | 1 | Block can accept a snoop |
| req_addr | input | AW | Line address of the snoop |
| req_op | input | 1 | 0 = share, 1 = invalidate |
| req_chk | input | 1 | 1 = presence must be checked |
| loc_req | input | NL | Local fill/writeback/block-store requests, index 0 highest priority |
| loc_gnt | output | NL | One-hot grant of the tag store to a local operation |
| tag_addr | output | AW | Tag store address for the snoop |
| tag_rd_en | output | 1 | Tag read strobe; data returns the next cycle |
| tag_rd_state | input | 2 | Line state read from the tag store |
| tag_wr_en | output | 1 | Tag write strobe |
| tag_wr_state | output | 2 | New line state to write |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Controller accepts the reply |
| rsp_code | output | 2 | 0 = ACK, 1 = DACK, 2 = NACK |

## Verification
The assertions check several properties on every cycle. They check the single-outstanding handshake, one local grant at most, and that no local grant occurs inside a snoop's read-to-reply window. They also check that a NACK never follows a tag write, that an unchecked snoop never gets a NACK, that a stalled reply stays stable, and that latency stays within the bound. Other properties only the bench scenarios can show. These are the state written for each combination of flag, operation and starting state, the one-cycle saving of the unchecked path, and the order of grants when an in-progress local operation, a waiting snoop and a late local request meet.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHD = 2'd1,
        ST_EXC = 2'd2,
        ST_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        RSP_ACK  = 2'd0,
        RSP_DACK = 2'd1,
        RSP_NACK = 2'd2
    } rsp_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARB,
        S_RD,
        S_PROBE,
        S_WR,
        S_RSP
    } snp_fsm_t;

    localparam logic OP_SHARE = 1'b0;
    localparam logic OP_INVAL = 1'b1;

    // State written back by a snoop; identical for either presence flag.
    function automatic line_st_t snoop_next(input logic op, input line_st_t cur);
        if (op == OP_INVAL || cur == ST_INV) begin
            return ST_INV;
        end
        return ST_SHD;
    endfunction

endpackage

// File: rtl/snp_arb.sv
module snp_arb #(
    parameter int NL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] loc_req,
    input  logic          snp_req,
    input  logic          snp_hold,
    output logic [NL-1:0] loc_gnt,
    output logic          snp_gnt
);

    typedef struct packed {
        logic          snp;
        logic [NL-1:0] loc;
    } owner_t;

    owner_t own_d, own_q;

    always_comb begin
        logic found;
        own_d = own_q;
        found = 1'b0;
        if (own_q.snp) begin
            if (!snp_req && !snp_hold) begin
                own_d.snp = 1'b0;
            end
        end else if (|own_q.loc) begin
            // in-progress local operation keeps the store until it lets go
            if (!(|(own_q.loc & loc_req))) begin
                own_d.loc = '0;
            end
        end else if (snp_req) begin
            own_d.snp = 1'b1;
        end else begin
            for (int i = 0; i < NL; i++) begin
                if (!found && loc_req[i]) begin
                    own_d.loc[i] = 1'b1;
                    found        = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0;
        end else begin
            own_q <= own_d;
        end
    end

    assign loc_gnt = own_q.loc;
    assign snp_gnt = own_q.snp;

endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl
    import snp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_op,
    input  logic          req_chk,
    output logic          snp_req,
    output logic          snp_hold,
    input  logic          snp_gnt,
    output logic [AW-1:0] tag_addr,
    output logic          tag_rd_en,
    input  logic [1:0]    tag_rd_state,
    output logic          tag_wr_en,
    output logic [1:0]    tag_wr_state,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [1:0]    rsp_code
);

    typedef struct packed {
        snp_fsm_t      st;
        logic [AW-1:0] addr;
        logic          op;
        logic          chk;
        line_st_t      cur;
        rsp_t          code;
    } ctrl_t;

    ctrl_t    c_d, c_q;
    line_st_t cur_eff;
    line_st_t new_st;

    // Unchecked snoops take the state straight from the read of the update.
    assign cur_eff = c_q.chk ? c_q.cur : line_st_t'(tag_rd_state);
    assign new_st  = snoop_next(c_q.op, cur_eff);

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    c_d.addr = req_addr;
                    c_d.op   = req_op;
                    c_d.chk  = req_chk;
                    c_d.st   = S_ARB;
                end
            end
            S_ARB: begin
                if (snp_gnt) begin
                    c_d.st = S_RD;
                end
            end
            S_RD: begin
                c_d.st = c_q.chk ? S_PROBE : S_WR;
            end
            S_PROBE: begin
                c_d.cur = line_st_t'(tag_rd_state);
                if (line_st_t'(tag_rd_state) == ST_INV) begin
                    c_d.code = RSP_NACK;
                    c_d.st   = S_RSP;
                end else begin
                    c_d.st = S_WR;
                end
            end
            S_WR: begin
                c_d.code = (cur_eff == ST_MOD) ? RSP_DACK : RSP_ACK;
                c_d.st   = S_RSP;
            end
            S_RSP: begin
                if (rsp_ready) begin
                    c_d.st = S_IDLE;
                end
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: S_IDLE, addr: '0, op: 1'b0, chk: 1'b0,
                     cur: ST_INV, code: RSP_ACK};
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready    = (c_q.st == S_IDLE);
    assign snp_req      = (c_q.st == S_ARB);
    assign snp_hold     = (c_q.st == S_RD) || (c_q.st == S_PROBE) || (c_q.st == S_WR);
    assign tag_addr     = c_q.addr;
    assign tag_rd_en    = (c_q.st == S_RD);
    assign tag_wr_en    = (c_q.st == S_WR);
    assign tag_wr_state = new_st;
    assign rsp_valid    = (c_q.st == S_RSP);
    assign rsp_code     = c_q.code;

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder #(
    parameter int AW = 8,
    parameter int NL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_op,
    input  logic          req_chk,
    input  logic [NL-1:0] loc_req,
    output logic [NL-1:0] loc_gnt,
    output logic [AW-1:0] tag_addr,
    output logic          tag_rd_en,
    input  logic [1:0]    tag_rd_state,
    output logic          tag_wr_en,
    output logic [1:0]    tag_wr_state,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [1:0]    rsp_code
);

    logic snp_req;
    logic snp_hold;
    logic snp_gnt;

    snp_arb #(.NL(NL)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .loc_req  (loc_req),
        .snp_req  (snp_req),
        .snp_hold (snp_hold),
        .loc_gnt  (loc_gnt),
        .snp_gnt  (snp_gnt)
    );

    snp_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_op       (req_op),
        .req_chk      (req_chk),
        .snp_req      (snp_req),
        .snp_hold     (snp_hold),
        .snp_gnt      (snp_gnt),
        .tag_addr     (tag_addr),
        .tag_rd_en    (tag_rd_en),
        .tag_rd_state (tag_rd_state),
        .tag_wr_en    (tag_wr_en),
        .tag_wr_state (tag_wr_state),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_code     (rsp_code)
    );

endmodule

// File: rtl/snp_chk.sv
module snp_chk #(
    parameter int NL      = 3,
    parameter int LAT_MAX = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_chk,
    input logic [NL-1:0] loc_gnt,
    input logic          tag_rd_en,
    input logic          tag_wr_en,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [1:0]    rsp_code
);

    localparam int LW = $clog2(LAT_MAX + 2) + 1;

    logic          outst;
    logic          chk_r;
    logic          wr_seen;
    logic          rd_seen;
    logic [LW-1:0] lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst   <= 1'b0;
            chk_r   <= 1'b0;
            wr_seen <= 1'b0;
            rd_seen <= 1'b0;
            lat     <= '0;
        end else if (req_valid && req_ready) begin
            outst   <= 1'b1;
            chk_r   <= req_chk;
            wr_seen <= 1'b0;
            rd_seen <= 1'b0;
            lat     <= '0;
        end else begin
            if (rsp_valid && rsp_ready) outst <= 1'b0;
            if (tag_wr_en) wr_seen <= 1'b1;
            if (tag_rd_en) rd_seen <= 1'b1;
            if (outst && !rsp_valid && lat != '1) lat <= lat + 1'b1;
        end
    end

    a_r1_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outst |-> !req_ready);

    a_r2_reply_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> outst);

    a_r3_nack_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> !wr_seen);

    a_r5_unchecked_never_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !chk_r) |-> rsp_code != 2'd2);

    a_r7_no_local_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_seen && outst && !rsp_valid) || tag_rd_en || tag_wr_en) |-> loc_gnt == '0);

    a_r8_single_local_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(loc_gnt));

    a_r9_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        outst |-> lat <= LW'(LAT_MAX));

    a_r10_reply_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code)));

endmodule

bind snoop_responder snp_chk #(.NL(NL), .LAT_MAX(30)) u_snp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_chk   (req_chk),
    .loc_gnt   (loc_gnt),
    .tag_rd_en (tag_rd_en),
    .tag_wr_en (tag_wr_en),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_code  (rsp_code)
);

// File: tb/tb_snoop_responder.sv
module tb_snoop_responder;

    localparam int AW      = 8;
    localparam int NL      = 3;
    localparam int LAT_MAX = 30;
    localparam int NVEC    = 9;

    logic          clk;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          req_op;
    logic          req_chk;
    logic [NL-1:0] loc_req;
    logic [NL-1:0] loc_gnt;
    logic [AW-1:0] tag_addr;
    logic          tag_rd_en;
    logic [1:0]    tag_rd_state;
    logic          tag_wr_en;
    logic [1:0]    tag_wr_state;
    logic          rsp_valid;
    logic          rsp_ready;
    logic [1:0]    rsp_code;

    snoop_responder #(.AW(AW), .NL(NL)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_op       (req_op),
        .req_chk      (req_chk),
        .loc_req      (loc_req),
        .loc_gnt      (loc_gnt),
        .tag_addr     (tag_addr),
        .tag_rd_en    (tag_rd_en),
        .tag_rd_state (tag_rd_state),
        .tag_wr_en    (tag_wr_en),
        .tag_wr_state (tag_wr_state),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_code     (rsp_code)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Tag store model: one-cycle read latency, preload port for the bench.
    logic [1:0]    mem [256];
    logic          pre_en;
    logic [AW-1:0] pre_addr;
    logic [1:0]    pre_val;
    logic [1:0]    rd_q;

    always @(posedge clk) begin
        if (pre_en)    mem[pre_addr] <= pre_val;
        if (tag_wr_en) mem[tag_addr] <= tag_wr_state;
        if (tag_rd_en) rd_q <= mem[tag_addr];
    end
    assign tag_rd_state = rd_q;

    // Monitors, sampled at the falling edge.
    int  n_chk = 0, n_fail = 0;
    int  n_req = 0, n_rsp = 0, n_wr = 0, n_viol = 0;
    int  cyc = 0;
    bit  in_snp = 0;
    bit  done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid && req_ready) n_req++;
            if (rsp_valid && rsp_ready) n_rsp++;
            if (tag_wr_en) n_wr++;
            if (tag_rd_en) in_snp = 1;
            if (in_snp && (|loc_gnt)) n_viol++;
            if (tag_wr_en || rsp_valid) in_snp = 0;
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic preload(input logic [AW-1:0] a, input logic [1:0] v);
        @(negedge clk);
        pre_en   = 1'b1;
        pre_addr = a;
        pre_val  = v;
        @(negedge clk);
        pre_en   = 1'b0;
    endtask

    // Returns at the falling edge where rsp_valid is first seen.
    task automatic do_snoop(input logic c, input logic o, input logic [AW-1:0] a,
                            output int lat, output logic [1:0] code);
        @(negedge clk);
        req_valid = 1'b1;
        req_chk   = c;
        req_op    = o;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        code = rsp_code;
    endtask

    // {chk, op, addr[7:0], initial state, expected code, expected new state}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'h10, 2'd3, 2'd1, 2'd1},
        {1'b1, 1'b0, 8'h11, 2'd2, 2'd0, 2'd1},
        {1'b1, 1'b1, 8'h12, 2'd1, 2'd0, 2'd0},
        {1'b1, 1'b0, 8'h13, 2'd0, 2'd2, 2'd0},
        {1'b1, 1'b1, 8'h14, 2'd3, 2'd1, 2'd0},
        {1'b0, 1'b0, 8'h20, 2'd3, 2'd1, 2'd1},
        {1'b0, 1'b1, 8'h21, 2'd2, 2'd0, 2'd0},
        {1'b0, 1'b0, 8'h22, 2'd0, 2'd0, 2'd0},
        {1'b0, 1'b1, 8'h23, 2'd1, 2'd0, 2'd0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int         lat, lat_chk1, lat_chk0;
        logic [1:0] code;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        req_op    = 1'b0;
        req_chk   = 1'b0;
        loc_req   = '0;
        rsp_ready = 1'b1;
        pre_en    = 1'b0;
        pre_addr  = '0;
        pre_val   = '0;
        lat_chk1  = 0;
        lat_chk0  = 0;
        repeat (3) @(negedge clk);

        // R11: reset state
        check(req_ready == 1'b1, "R11", "req_ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R11", "rsp_valid", int'(rsp_valid), 0);
        check(loc_gnt == '0, "R11", "loc_gnt", int'(loc_gnt), 0);
        check(!tag_rd_en && !tag_wr_en, "R11", "tag strobes",
              int'({tag_rd_en, tag_wr_en}), 0);
        rst_n = 1'b1;

        // Vector walk: R3 R4 R5 R6 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0]   v;
            logic [AW-1:0] a;
            int            wr0;
            string         rq;
            v  = VEC[i];
            a  = v[13:6];
            rq = v[15] ? ((v[5:4] == 2'd0) ? "R3" : "R4") : "R5";
            preload(a, v[5:4]);
            wr0 = n_wr;
            do_snoop(v[15], v[14], a, lat, code);
            check(code == v[3:2], rq, "reply code", int'(code), int'(v[3:2]));
            @(negedge clk);
            check(mem[a] == v[1:0], "R6", "new line state", int'(mem[a]), int'(v[1:0]));
            check(n_wr - wr0 == ((v[3:2] == 2'd2) ? 0 : 1), rq, "tag write count",
                  n_wr - wr0, (v[3:2] == 2'd2) ? 0 : 1);
            check(lat <= LAT_MAX, "R9", "latency", lat, LAT_MAX);
            if (i == 0) lat_chk1 = lat;
            if (i == 5) lat_chk0 = lat;
        end
        // R5: unchecked path answers sooner
        check(lat_chk0 < lat_chk1, "R5", "unchecked latency below checked",
              lat_chk0, lat_chk1 - 1);

        // R1 / R10: stalled reply
        preload(8'h40, 2'd3);
        rsp_ready = 1'b0;
        do_snoop(1'b1, 1'b0, 8'h40, lat, code);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(rsp_valid && rsp_code == 2'd1, "R10", "stalled reply held",
                  int'({rsp_valid, rsp_code}), 5);
            check(req_ready == 1'b0, "R1", "ready while outstanding", int'(req_ready), 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after handshake", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1", "reply dropped", int'(rsp_valid), 0);

        // R8: in-progress local first, then snoop, then late local request
        preload(8'h30, 2'd2);
        @(negedge clk);
        loc_req[0] = 1'b1;
        while (!loc_gnt[0]) @(negedge clk);
        begin
            int t_rd, t_g1;
            bit held_ok;
            t_rd    = -1;
            t_g1    = -1;
            held_ok = 1;
            fork
                begin
                    int         l2;
                    logic [1:0] c2;
                    do_snoop(1'b1, 1'b0, 8'h30, l2, c2);
                    check(c2 == 2'd0, "R4", "contended reply code", int'(c2), 0);
                    check(l2 <= LAT_MAX, "R9", "contended latency", l2, LAT_MAX);
                end
                begin
                    repeat (2) @(negedge clk);
                    loc_req[1] = 1'b1;
                end
                begin
                    for (int k = 0; k < 6; k++) begin
                        @(negedge clk);
                        if (!loc_gnt[0]) held_ok = 0;
                    end
                    loc_req[0] = 1'b0;
                end
                begin
                    for (int k = 0; k < 60 && (t_rd < 0 || t_g1 < 0); k++) begin
                        @(negedge clk);
                        if (tag_rd_en && t_rd < 0) t_rd = cyc;
                        if (loc_gnt[1] && t_g1 < 0) t_g1 = cyc;
                    end
                end
            join
            check(held_ok, "R8", "in-progress local grant kept", int'(held_ok), 1);
            check(t_rd >= 0 && t_g1 > t_rd, "R8", "snoop read before late local grant",
                  t_g1, t_rd + 1);
        end
        repeat (3) @(negedge clk);
        loc_req[1] = 1'b0;
        repeat (3) @(negedge clk);
        check(mem[8'h30] == 2'd1, "R6", "contended line state", int'(mem[8'h30]), 1);

        // R2 / R7 totals
        check(n_req == n_rsp, "R2", "replies equal requests", n_rsp, n_req);
        check(n_viol == 0, "R7", "local grants inside snoop", n_viol, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule